// File: doc/BRIEF.md
# DSI Bridge Power-Up Sequencer

This block brings a parallel-RGB-to-DSI bridge from power-on to streaming video without software stepping through the bring-up. After a `start` pulse it holds the bridge in reset, releases it, and optionally confirms through register reads that the bridge answers with the right identity and its reset-time control word. It then walks a fixed, ordered list of register writes through a simple request/done access port. The writes cover the video timings, the pixel format and lane count, the control word with the data lanes left in low-power signalling, and the PLL setup. The PLL then gets a lock wait, two panel commands (leave sleep, turn display on) follow with their own waits, and a last control write switches the data lanes to high-speed and turns on the video path.

The serial framing of each access and the PLL arithmetic are handled elsewhere. The sequencer receives the finished PLL word and low-power divider code as inputs, and hands each access to an external port engine that raises `acc_done` once the access is complete. All waits come from one prescaled timer, sized by the number of system clocks per microsecond and microseconds per millisecond. The outcome is reported on `busy`, `done` and `err`.

Top module: `dsi_bringup_seq`

## Requirements
- R1: After `start`, `bridge_rst_n` is low for at least RESET_MS milliseconds and then high for at least RESET_MS milliseconds before the first access request. While `bridge_rst_n` is low, `acc_req` stays low. After block reset, `bridge_rst_n` is low and `busy`, `done`, `err` and `acc_req` are low.
- R2: With `readback_en` high, the first two accesses are reads (`acc_write`=0): address 0xB0, which must return 0x2828, then address 0xB7, which must return 0x0301. A mismatch ends the run with `err` high and no further access. With `readback_en` low, no read is issued.
- R3: The timing writes go out in this order, with the high byte listed first in each word:
  - 0xB1 = {vsync_len, hsync_len}
  - 0xB2 = {vsync_len+vback, hsync_len+hback} (each sum taken modulo 256)
  - 0xB3 = {vfront, hfront}
  - 0xB4 = hactive
  - 0xB5 = vactive
- R4: 0xB6 is then written with 0x0008 OR a format code. The code is 0 for `bpp`=16, 1 for 18 with `loose18`=0, 2 for 18 with `loose18`=1, and 3 for 24. Next, 0xDE is written with `lanes`-1.
- R5: If `bpp` is any other value, the run ends with `err` high right after the 0xB5 write, and 0xB6 is never written.
- R6: The next write is 0xB7 = 0x0342, with bit 5 also set when `pix_ref` is high (giving 0x0362).
- R7: Then, in order: 0xBA = `pll_word`, 0xB8 = 0, 0xBB = `lp_div_code`, 0xB9 = 1. After that, no request is raised for at least LOCK_US microseconds.
- R8: Then, in order: 0xBC = 1, 0xBF = 0x11, a wait of `wake_delay_ms`, then 0xBC = 1, 0xBF = 0x29, and a wait of `on_delay_ms`. A zero delay adds no wait.
- R9: The final write is 0xB7 = (the R6 word) OR 0x0009. After it, `done` rises, `busy` falls, and no further request is made.
- R10: `acc_req` stays high with `acc_write`, `acc_addr` and `acc_wdata` stable until `acc_done` is seen. It falls in the cycle after that, and only one access is outstanding at a time.
- R11: `busy` is high from the cycle after an accepted `start` until `done` or `err`. A `start` pulse while busy has no effect.
- R12: A `start` while `done` or `err` is high begins the whole sequence again from the reset step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Pulse to begin bring-up |
| readback_en | input | 1 | Bridge reads are available; enables the identity check |
| vsync_len | input | 8 | Vertical sync length in lines |
| hsync_len | input | 8 | Horizontal sync length in pixels |
| vback | input | 8 | Vertical back porch |
| hback | input | 8 | Horizontal back porch |
| vfront | input | 8 | Vertical front porch |
| hfront | input | 8 | Horizontal front porch |
| hactive | input | DIM_W | Active width |
| vactive | input | DIM_W | Active height |
| bpp | input | 5 | Colour depth: 16, 18 or 24 |
| loose18 | input | 1 | 18 bpp uses the loosely packed format |
| lanes | input | LANE_W | Number of data lanes |
| pix_ref | input | 1 | PLL reference is the pixel clock |
| pll_word | input | 16 | Precomputed PLL configuration word |
| lp_div_code | input | 16 | Precomputed low-power clock divider code |
| wake_delay_ms | input | DLY_W | Wait after the leave-sleep command, in ms |
| on_delay_ms | input | DLY_W | Wait after the display-on command, in ms |
| bridge_rst_n | output | 1 | Active-low reset to the bridge |
| acc_req | output | 1 | Register access request |
| acc_write | output | 1 | 1 = write, 0 = read |
| acc_addr | output | 8 | Bridge register address |
| acc_wdata | output | 16 | Write data (carries the expected value on reads) |
| acc_rdata | input | 16 | Read data, valid with acc_done |
| acc_done | input | 1 | Access complete |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished successfully |
| err | output | 1 | Sequence aborted |

## Verification
A wrong program counter or a wrong step decode shows up at the very next request as a wrong address, direction or data word. It is therefore caught by comparing every completed access with the expected ordered list, within one access of the fault. A timer that loses or gains units shows up as the idle gap before the next request: the lock wait, the two panel waits and the two reset phases are each measured in cycles against their programmed lengths. A lost abort shows up as a stray access after an identity mismatch or a bad colour depth, and a wrongly accepted restart shows up as a second reset phase or a repeated access.

// File: rtl/dsi_seq_pkg.sv
// Package: shared types and constants for the bridge power-up sequencer.
// Assumes a bridge whose registers are 16 bits wide with 8-bit addresses.
package dsi_seq_pkg;

    localparam int REG_W     = 16;
    localparam int NUM_STEPS = 25;
    localparam int PC_W      = $clog2(NUM_STEPS + 1);

    // Bridge register addresses used by the bring-up list
    localparam logic [7:0] A_IDENT   = 8'hB0;
    localparam logic [7:0] A_SYNC    = 8'hB1;
    localparam logic [7:0] A_BACK    = 8'hB2;
    localparam logic [7:0] A_FRONT   = 8'hB3;
    localparam logic [7:0] A_HACT    = 8'hB4;
    localparam logic [7:0] A_VACT    = 8'hB5;
    localparam logic [7:0] A_VMODE   = 8'hB6;
    localparam logic [7:0] A_CTRL    = 8'hB7;
    localparam logic [7:0] A_VCHAN   = 8'hB8;
    localparam logic [7:0] A_PLLEN   = 8'hB9;
    localparam logic [7:0] A_PLLCFG  = 8'hBA;
    localparam logic [7:0] A_LPDIV   = 8'hBB;
    localparam logic [7:0] A_PKTLEN  = 8'hBC;
    localparam logic [7:0] A_PKTDATA = 8'hBF;
    localparam logic [7:0] A_LANES   = 8'hDE;

    localparam logic [REG_W-1:0] ID_EXPECT  = 16'h2828;
    localparam logic [REG_W-1:0] CTRL_RESET = 16'h0301;
    localparam logic [REG_W-1:0] BURST_MODE = 16'h0008;

    // Control word bit positions
    localparam int CB_HS_DATA = 0;
    localparam int CB_HS_CLK  = 1;
    localparam int CB_VIDEO   = 3;
    localparam int CB_PIXREF  = 5;
    localparam int CB_CMDONLY = 6;

    localparam logic [7:0] CMD_WAKE = 8'h11;
    localparam logic [7:0] CMD_ON   = 8'h29;

    typedef enum logic [2:0] {
        OP_HOLD_LOW, OP_RELEASE, OP_READ, OP_WRITE,
        OP_WAIT_US, OP_WAIT_MS, OP_FINISH
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ISSUE, ST_ACC, ST_TIME, ST_DONE, ST_FAIL
    } state_e;

    typedef struct packed {
        op_e              op;
        logic [7:0]       addr;
        logic [REG_W-1:0] data;   // write value, expected read value, or wait count
        logic             bad;    // step may not be issued: abort instead
    } step_t;

    // Pixel format lookup: returns {supported, code[1:0]}
    function automatic logic [2:0] pix_fmt(input logic [4:0] depth, input logic loose);
        case (depth)
            5'd16:   pix_fmt = 3'b100;
            5'd18:   pix_fmt = loose ? 3'b110 : 3'b101;
            5'd24:   pix_fmt = 3'b111;
            default: pix_fmt = 3'b000;
        endcase
    endfunction

endpackage

// File: rtl/dsi_seq_timer.sv
// Module: prescaled wait timer. Counts a number of microsecond or millisecond
// units and gives a one-cycle fire pulse when done. A count of zero fires
// on the cycle after start. Assumes start is only given while idle.
module dsi_seq_timer #(
    parameter int CLK_PER_US = 200,
    parameter int US_PER_MS  = 1000,
    parameter int CNT_W      = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             unit_ms,
    input  logic [CNT_W-1:0] count,
    output logic             fire
);
    localparam int MS_CYC = CLK_PER_US * US_PER_MS;
    localparam int PRE_W  = (MS_CYC > 1) ? $clog2(MS_CYC) : 1;
    localparam logic [PRE_W-1:0] MS_LAST = PRE_W'(MS_CYC - 1);
    localparam logic [PRE_W-1:0] US_LAST = PRE_W'(CLK_PER_US - 1);

    logic             run;
    logic             ms_q;
    logic [CNT_W-1:0] rem;
    logic [PRE_W-1:0] pre;
    logic [PRE_W-1:0] unit_last;

    // Last prescaler value of the selected unit
    always_comb unit_last = ms_q ? MS_LAST : US_LAST;

    // Unit countdown with prescaler; fire once when the units are used up
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run  <= 1'b0;
            ms_q <= 1'b0;
            rem  <= '0;
            pre  <= '0;
            fire <= 1'b0;
        end else begin
            fire <= 1'b0;
            if (start) begin
                run  <= 1'b1;
                ms_q <= unit_ms;
                rem  <= count;
                pre  <= '0;
            end else if (run) begin
                if (rem == '0) begin
                    run  <= 1'b0;
                    fire <= 1'b1;
                end else if (pre == unit_last) begin
                    pre <= '0;
                    rem <= rem - CNT_W'(1);
                end else begin
                    pre <= pre + PRE_W'(1);
                end
            end
        end
    end

    // R7: a wait is never restarted while one is running
    p_start_when_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !run);

    // R8: the completion pulse lasts exactly one cycle
    p_fire_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !fire);

endmodule

// File: rtl/dsi_seq_access.sv
// Module: access port driver. Latches one register access when told to go,
// holds the request with stable fields until the port engine reports done,
// then gives a one-cycle finish pulse with the captured read data.
// Assumes go is only given while no request is outstanding.
module dsi_seq_access
    import dsi_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic             wr_i,
    input  logic [7:0]       addr_i,
    input  logic [REG_W-1:0] data_i,
    output logic             req_o,
    output logic             wr_o,
    output logic [7:0]       addr_o,
    output logic [REG_W-1:0] data_o,
    input  logic [REG_W-1:0] rdata_i,
    input  logic             done_i,
    output logic             fin_o,
    output logic [REG_W-1:0] rdata_o
);
    // Request/done handshake with field capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_o   <= 1'b0;
            wr_o    <= 1'b0;
            addr_o  <= '0;
            data_o  <= '0;
            fin_o   <= 1'b0;
            rdata_o <= '0;
        end else begin
            fin_o <= 1'b0;
            if (go && !req_o) begin
                req_o  <= 1'b1;
                wr_o   <= wr_i;
                addr_o <= addr_i;
                data_o <= data_i;
            end else if (req_o && done_i) begin
                req_o   <= 1'b0;
                fin_o   <= 1'b1;
                rdata_o <= rdata_i;
            end
        end
    end

    // R10: fields hold while the request waits for done
    p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && !done_i) |=> (req_o && $stable(addr_o) && $stable(data_o) && $stable(wr_o)));

    // R10: the request drops right after done
    p_req_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && done_i) |=> !req_o);

    // R10: no new access is launched over an outstanding one
    p_single_access_r10: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> !req_o);

endmodule

// File: rtl/dsi_seq_steps.sv
// Module: bring-up step list. Maps a step index to the operation, address
// and data for that step, built from the configuration inputs. Purely
// combinational; assumes the configuration is held stable during a run.
module dsi_seq_steps
    import dsi_seq_pkg::*;
#(
    parameter int DIM_W    = 16,
    parameter int LANE_W   = 3,
    parameter int DLY_W    = 8,
    parameter int RESET_MS = 10,
    parameter int LOCK_US  = 500
) (
    input  logic [PC_W-1:0]   pc,
    input  logic [7:0]        vsync_len,
    input  logic [7:0]        hsync_len,
    input  logic [7:0]        vback,
    input  logic [7:0]        hback,
    input  logic [7:0]        vfront,
    input  logic [7:0]        hfront,
    input  logic [DIM_W-1:0]  hactive,
    input  logic [DIM_W-1:0]  vactive,
    input  logic [4:0]        bpp,
    input  logic              loose18,
    input  logic [LANE_W-1:0] lanes,
    input  logic              pix_ref,
    input  logic [REG_W-1:0]  pll_word,
    input  logic [REG_W-1:0]  lp_div_code,
    input  logic [DLY_W-1:0]  wake_delay_ms,
    input  logic [DLY_W-1:0]  on_delay_ms,
    output step_t             step
);
    logic [7:0]        vsum;
    logic [7:0]        hsum;
    logic [2:0]        fmt;
    logic [LANE_W-1:0] lanes_m1;
    logic [REG_W-1:0]  ctrl_lp;
    logic [REG_W-1:0]  ctrl_hs;

    // Derived register values
    always_comb begin
        vsum     = vsync_len + vback;
        hsum     = hsync_len + hback;
        fmt      = pix_fmt(bpp, loose18);
        lanes_m1 = lanes - LANE_W'(1);
        ctrl_lp  = CTRL_RESET;
        ctrl_lp[CB_PIXREF]  = pix_ref;
        ctrl_lp[CB_HS_DATA] = 1'b0;
        ctrl_lp[CB_HS_CLK]  = 1'b1;
        ctrl_lp[CB_CMDONLY] = 1'b1;
        ctrl_hs  = ctrl_lp;
        ctrl_hs[CB_HS_DATA] = 1'b1;
        ctrl_hs[CB_VIDEO]   = 1'b1;
    end

    // Step decode by index
    always_comb begin
        step.op   = OP_WRITE;
        step.addr = '0;
        step.data = '0;
        step.bad  = 1'b0;
        case (pc)
            PC_W'(0):  begin step.op = OP_HOLD_LOW; step.data = REG_W'(RESET_MS); end
            PC_W'(1):  begin step.op = OP_RELEASE;  step.data = REG_W'(RESET_MS); end
            PC_W'(2):  begin step.op = OP_READ; step.addr = A_IDENT; step.data = ID_EXPECT;  end
            PC_W'(3):  begin step.op = OP_READ; step.addr = A_CTRL;  step.data = CTRL_RESET; end
            PC_W'(4):  begin step.addr = A_SYNC;  step.data = {vsync_len, hsync_len}; end
            PC_W'(5):  begin step.addr = A_BACK;  step.data = {vsum, hsum};           end
            PC_W'(6):  begin step.addr = A_FRONT; step.data = {vfront, hfront};       end
            PC_W'(7):  begin step.addr = A_HACT;  step.data = REG_W'(hactive);        end
            PC_W'(8):  begin step.addr = A_VACT;  step.data = REG_W'(vactive);        end
            PC_W'(9):  begin
                step.addr = A_VMODE;
                step.data = BURST_MODE | REG_W'(fmt[1:0]);
                step.bad  = !fmt[2];
            end
            PC_W'(10): begin step.addr = A_LANES;  step.data = REG_W'(lanes_m1); end
            PC_W'(11): begin step.addr = A_CTRL;   step.data = ctrl_lp;          end
            PC_W'(12): begin step.addr = A_PLLCFG; step.data = pll_word;         end
            PC_W'(13): begin step.addr = A_VCHAN;  step.data = '0;               end
            PC_W'(14): begin step.addr = A_LPDIV;  step.data = lp_div_code;      end
            PC_W'(15): begin step.addr = A_PLLEN;  step.data = REG_W'(1);        end
            PC_W'(16): begin step.op = OP_WAIT_US; step.data = REG_W'(LOCK_US);  end
            PC_W'(17): begin step.addr = A_PKTLEN;  step.data = REG_W'(1);       end
            PC_W'(18): begin step.addr = A_PKTDATA; step.data = REG_W'(CMD_WAKE); end
            PC_W'(19): begin step.op = OP_WAIT_MS; step.data = REG_W'(wake_delay_ms); end
            PC_W'(20): begin step.addr = A_PKTLEN;  step.data = REG_W'(1);       end
            PC_W'(21): begin step.addr = A_PKTDATA; step.data = REG_W'(CMD_ON);  end
            PC_W'(22): begin step.op = OP_WAIT_MS; step.data = REG_W'(on_delay_ms); end
            PC_W'(23): begin step.addr = A_CTRL; step.data = ctrl_hs; end
            default:   begin step.op = OP_FINISH; end
        endcase
    end

endmodule

// File: rtl/dsi_bringup_seq.sv
// Module: DSI bridge power-up sequencer (top). Walks the bring-up step list:
// drives the bridge reset, issues each register access through the access
// driver, checks read values, runs the waits on the prescaled timer, and
// reports busy/done/err. Assumes configuration inputs are stable while busy
// and DIM_W is at most 16.
module dsi_bringup_seq
    import dsi_seq_pkg::*;
#(
    parameter int CLK_PER_US = 200,
    parameter int US_PER_MS  = 1000,
    parameter int RESET_MS   = 10,
    parameter int LOCK_US    = 500,
    parameter int DIM_W      = 16,
    parameter int LANE_W     = 3,
    parameter int DLY_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              readback_en,
    input  logic [7:0]        vsync_len,
    input  logic [7:0]        hsync_len,
    input  logic [7:0]        vback,
    input  logic [7:0]        hback,
    input  logic [7:0]        vfront,
    input  logic [7:0]        hfront,
    input  logic [DIM_W-1:0]  hactive,
    input  logic [DIM_W-1:0]  vactive,
    input  logic [4:0]        bpp,
    input  logic              loose18,
    input  logic [LANE_W-1:0] lanes,
    input  logic              pix_ref,
    input  logic [15:0]       pll_word,
    input  logic [15:0]       lp_div_code,
    input  logic [DLY_W-1:0]  wake_delay_ms,
    input  logic [DLY_W-1:0]  on_delay_ms,
    output logic              bridge_rst_n,
    output logic              acc_req,
    output logic              acc_write,
    output logic [7:0]        acc_addr,
    output logic [15:0]       acc_wdata,
    input  logic [15:0]       acc_rdata,
    input  logic              acc_done,
    output logic              busy,
    output logic              done,
    output logic              err
);
    state_e           state;
    logic [PC_W-1:0]  pc;
    logic             rst_q;
    step_t            step;
    logic             timed_op;
    logic             tmr_start;
    logic             tmr_unit_ms;
    logic             tmr_fire;
    logic             acc_go;
    logic             acc_fin;
    logic [REG_W-1:0] acc_rd_q;
    logic [2:0]       fmt_chk;

    dsi_seq_steps #(
        .DIM_W(DIM_W), .LANE_W(LANE_W), .DLY_W(DLY_W),
        .RESET_MS(RESET_MS), .LOCK_US(LOCK_US)
    ) u_steps (
        .pc(pc), .vsync_len(vsync_len), .hsync_len(hsync_len),
        .vback(vback), .hback(hback), .vfront(vfront), .hfront(hfront),
        .hactive(hactive), .vactive(vactive), .bpp(bpp), .loose18(loose18),
        .lanes(lanes), .pix_ref(pix_ref), .pll_word(pll_word),
        .lp_div_code(lp_div_code), .wake_delay_ms(wake_delay_ms),
        .on_delay_ms(on_delay_ms), .step(step)
    );

    dsi_seq_timer #(
        .CLK_PER_US(CLK_PER_US), .US_PER_MS(US_PER_MS), .CNT_W(REG_W)
    ) u_timer (
        .clk(clk), .rst_n(rst_n), .start(tmr_start), .unit_ms(tmr_unit_ms),
        .count(step.data), .fire(tmr_fire)
    );

    dsi_seq_access u_access (
        .clk(clk), .rst_n(rst_n), .go(acc_go), .wr_i(step.op == OP_WRITE),
        .addr_i(step.addr), .data_i(step.data), .req_o(acc_req),
        .wr_o(acc_write), .addr_o(acc_addr), .data_o(acc_wdata),
        .rdata_i(acc_rdata), .done_i(acc_done), .fin_o(acc_fin),
        .rdata_o(acc_rd_q)
    );

    // Launch decisions for the current step
    always_comb begin
        timed_op    = (step.op == OP_HOLD_LOW) || (step.op == OP_RELEASE) ||
                      (step.op == OP_WAIT_US)  || (step.op == OP_WAIT_MS);
        tmr_start   = (state == ST_ISSUE) && timed_op;
        tmr_unit_ms = (step.op != OP_WAIT_US);
        acc_go      = (state == ST_ISSUE) &&
                      (((step.op == OP_READ) && readback_en) ||
                       ((step.op == OP_WRITE) && !step.bad));
    end

    // Sequencer state, step index and bridge reset level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            pc    <= '0;
            rst_q <= 1'b0;
        end else begin
            case (state)
                ST_IDLE, ST_DONE, ST_FAIL: begin
                    if (start) begin
                        pc    <= '0;
                        state <= ST_ISSUE;
                    end
                end
                ST_ISSUE: begin
                    case (step.op)
                        OP_HOLD_LOW: begin rst_q <= 1'b0; state <= ST_TIME; end
                        OP_RELEASE:  begin rst_q <= 1'b1; state <= ST_TIME; end
                        OP_WAIT_US, OP_WAIT_MS: state <= ST_TIME;
                        OP_READ: begin
                            if (readback_en) state <= ST_ACC;
                            else             pc    <= pc + PC_W'(1);
                        end
                        OP_WRITE: state <= step.bad ? ST_FAIL : ST_ACC;
                        default:  state <= ST_DONE;
                    endcase
                end
                ST_ACC: begin
                    if (acc_fin) begin
                        if ((step.op == OP_READ) && (acc_rd_q != step.data)) begin
                            state <= ST_FAIL;
                        end else begin
                            pc    <= pc + PC_W'(1);
                            state <= ST_ISSUE;
                        end
                    end
                end
                ST_TIME: begin
                    if (tmr_fire) begin
                        pc    <= pc + PC_W'(1);
                        state <= ST_ISSUE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Status outputs
    always_comb begin
        bridge_rst_n = rst_q;
        busy         = (state == ST_ISSUE) || (state == ST_ACC) || (state == ST_TIME);
        done         = (state == ST_DONE);
        err          = (state == ST_FAIL);
    end

    // Independent format decode used only by the checks below
    always_comb fmt_chk = pix_fmt(bpp, loose18);

    // R1: no access while the bridge is held in reset
    p_quiet_in_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !bridge_rst_n |-> !acc_req);

    // R5: the mode register is never written with an unsupported depth
    p_no_bad_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req && acc_write && (acc_addr == A_VMODE)) |-> fmt_chk[2]);

    // R9: nothing is requested once the run has ended
    p_quiet_when_ended_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done || err) |-> !acc_req);

    // R11: an accepted start makes the block busy on the next cycle
    p_start_to_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R12: a run restarted from done or err begins with the reset phase
    p_restart_resets_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ((done || err) && start) |=> ##1 !bridge_rst_n);

endmodule

// File: tb/tb_dsi_bringup_seq.sv
`timescale 1ns/1ps
module tb_dsi_bringup_seq;

    localparam int CPU   = 2;
    localparam int UPM   = 10;
    localparam int MSC   = CPU * UPM;      // cycles per ms
    localparam int RSTC  = 10 * MSC;       // reset phase cycles
    localparam int LOCKC = 500 * CPU;      // lock wait cycles
    localparam int SLACK = 12;

    typedef struct packed {
        logic        wr;
        logic [7:0]  addr;
        logic [15:0] data;
    } xact_t;

    logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0, readback_en = 1'b0;
    logic [7:0]  vsync_len, hsync_len, vback, hback, vfront, hfront;
    logic [15:0] hactive, vactive;
    logic [4:0]  bpp;
    logic        loose18, pix_ref;
    logic [2:0]  lanes;
    logic [15:0] pll_word, lp_div_code;
    logic [7:0]  wake_delay_ms, on_delay_ms;
    logic        bridge_rst_n, acc_req, acc_write, busy, done, err;
    logic [7:0]  acc_addr;
    logic [15:0] acc_wdata;
    logic [15:0] acc_rdata = 16'h0;
    logic        acc_done = 1'b0;

    dsi_bringup_seq #(.CLK_PER_US(CPU), .US_PER_MS(UPM)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .readback_en(readback_en),
        .vsync_len(vsync_len), .hsync_len(hsync_len), .vback(vback), .hback(hback),
        .vfront(vfront), .hfront(hfront), .hactive(hactive), .vactive(vactive),
        .bpp(bpp), .loose18(loose18), .lanes(lanes), .pix_ref(pix_ref),
        .pll_word(pll_word), .lp_div_code(lp_div_code),
        .wake_delay_ms(wake_delay_ms), .on_delay_ms(on_delay_ms),
        .bridge_rst_n(bridge_rst_n), .acc_req(acc_req), .acc_write(acc_write),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .acc_done(acc_done), .busy(busy), .done(done), .err(err)
    );

    always #2.5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0, fails = 0;
    xact_t exp_q[$];
    string tag_q[$];

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, expv);
        end
    endtask

    task automatic push(input logic wr, input logic [7:0] a, input logic [15:0] d,
                        input string tag);
        exp_q.push_back({wr, a, d});
        tag_q.push_back(tag);
    endtask

    // Bridge model state
    logic [15:0] id_val  = 16'h2828;
    logic [15:0] ctl_val = 16'h0301;
    int    lat = 0, target = 0;
    bit    prev_req = 0, seq_active = 0, first_seen = 0;
    int    low_cnt = 0, high_cnt = 0, last_done_cyc = 0;
    xact_t last_item = '0;

    function automatic int gap_for(input xact_t it);
        if (it.wr && it.addr == 8'hB9) return LOCKC;
        if (it.wr && it.addr == 8'hBF && it.data == 16'h0011) return int'(wake_delay_ms) * MSC;
        if (it.wr && it.addr == 8'hBF && it.data == 16'h0029) return int'(on_delay_ms) * MSC;
        return 0;
    endfunction

    // Monitor and bridge responder: compares each completed access with the
    // scoreboard and measures reset phases and idle gaps
    always @(negedge clk) begin
        if (seq_active) begin
            if (!bridge_rst_n) low_cnt++;
            else if (!first_seen) high_cnt++;
        end
        if (acc_req && !prev_req) begin
            if (seq_active && !first_seen) begin
                first_seen = 1;
                chk(low_cnt >= RSTC && low_cnt <= RSTC + SLACK, "R1", "reset low cycles", low_cnt, RSTC);
                chk(high_cnt >= RSTC && high_cnt <= RSTC + SLACK, "R1", "reset high cycles", high_cnt, RSTC);
            end else begin
                int g, e;
                g = cyc - last_done_cyc;
                e = gap_for(last_item);
                if (last_item.addr == 8'hB9)
                    chk(g >= e && g <= e + SLACK, "R7", "lock wait gap", g, e);
                else if (last_item.addr == 8'hBF)
                    chk(g >= e && g <= e + SLACK, "R8", "panel wait gap", g, e);
                else
                    chk(g <= SLACK, "R10", "gap between accesses", g, e);
            end
        end
        prev_req = acc_req;
        if (acc_done) begin
            chk(!acc_req, "R10", "request after done", acc_req, 0);
            acc_done = 1'b0;
            lat = 0;
        end else if (acc_req) begin
            if (lat >= target) begin
                xact_t got, e;
                string t;
                got = {acc_write, acc_addr, acc_wdata};
                acc_rdata = (acc_addr == 8'hB0) ? id_val :
                            (acc_addr == 8'hB7) ? ctl_val : 16'hDEAD;
                acc_done = 1'b1;
                last_done_cyc = cyc;
                last_item = got;
                target = (target + 1) % 3;
                if (exp_q.size() == 0) begin
                    chk(0, "R11", "unexpected access", got, 0);
                end else begin
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk(got.wr == e.wr && got.addr == e.addr && (!e.wr || got.data == e.data),
                        t, "access", got, e);
                end
            end else begin
                lat++;
            end
        end
    end

    // Build the expected access list from the requirements
    task automatic build_expected();
        logic [1:0]  fmt;
        logic [15:0] c1;
        bit          ok;
        exp_q.delete();
        tag_q.delete();
        if (readback_en) begin
            push(0, 8'hB0, 16'h0, "R2");
            if (id_val != 16'h2828) return;
            push(0, 8'hB7, 16'h0, "R2");
            if (ctl_val != 16'h0301) return;
        end
        push(1, 8'hB1, {vsync_len, hsync_len}, "R3");
        push(1, 8'hB2, {8'(vsync_len + vback), 8'(hsync_len + hback)}, "R3");
        push(1, 8'hB3, {vfront, hfront}, "R3");
        push(1, 8'hB4, hactive, "R3");
        push(1, 8'hB5, vactive, "R3");
        ok = 1;
        case (bpp)
            5'd16: fmt = 2'd0;
            5'd18: fmt = loose18 ? 2'd2 : 2'd1;
            5'd24: fmt = 2'd3;
            default: begin fmt = 2'd0; ok = 0; end
        endcase
        if (!ok) return;   // R5: stop before the mode write
        push(1, 8'hB6, 16'h0008 | 16'(fmt), "R4");
        push(1, 8'hDE, 16'(lanes) - 16'd1, "R4");
        c1 = pix_ref ? 16'h0362 : 16'h0342;
        push(1, 8'hB7, c1, "R6");
        push(1, 8'hBA, pll_word, "R7");
        push(1, 8'hB8, 16'h0, "R7");
        push(1, 8'hBB, lp_div_code, "R7");
        push(1, 8'hB9, 16'h1, "R7");
        push(1, 8'hBC, 16'h1, "R8");
        push(1, 8'hBF, 16'h0011, "R8");
        push(1, 8'hBC, 16'h1, "R8");
        push(1, 8'hBF, 16'h0029, "R8");
        push(1, 8'hB7, c1 | 16'h0009, "R9");
    endtask

    task automatic set_cfg(input bit rb, input logic [4:0] depth, input bit loose,
                           input logic [2:0] nl, input bit pref, input logic [15:0] pll,
                           input logic [15:0] dv, input logic [7:0] wk, input logic [7:0] on);
        readback_en = rb; bpp = depth; loose18 = loose; lanes = nl; pix_ref = pref;
        pll_word = pll; lp_div_code = dv; wake_delay_ms = wk; on_delay_ms = on;
    endtask

    // Run one sequence and check its outcome
    task automatic run_seq(input bit expect_err, input bit mid_start, input string tag);
        int n;
        @(negedge clk);
        build_expected();
        low_cnt = 0; high_cnt = 0; first_seen = 0; seq_active = 1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1 && done == 1'b0 && err == 1'b0, "R11", "busy after start", busy, 1);
        if (mid_start) begin
            repeat (50) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            chk(busy == 1'b1, "R11", "busy kept after start while busy", busy, 1);
        end
        n = 0;
        while (!(done || err) && n < 20000) begin
            @(negedge clk);
            n++;
        end
        chk(n < 20000, tag, "run ended", n, 0);
        chk(err == expect_err && done == !expect_err, tag, "outcome {done,err}",
            {done, err}, {!expect_err, expect_err});
        chk(busy == 1'b0, "R11", "busy cleared at end", busy, 0);
        repeat (20) @(negedge clk);
        chk(acc_req == 1'b0, "R9", "no request after end", acc_req, 0);
        chk(exp_q.size() == 0, tag, "expected accesses left", exp_q.size(), 0);
        seq_active = 0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        wait (cyc > 150000);
        fails++;
        $display("FAIL watchdog expired actual=0x%0h expected=0x0", cyc);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        vsync_len = 8'd4;  hsync_len = 8'd10; vback = 8'd6; hback = 8'd20;
        vfront = 8'd8; hfront = 8'd30; hactive = 16'd800; vactive = 16'd480;
        set_cfg(1, 5'd24, 0, 3'd4, 0, 16'h4A21, 16'h0003, 8'd3, 8'd2);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(bridge_rst_n == 1'b0 && busy == 1'b0 && done == 1'b0 && err == 1'b0 && acc_req == 1'b0,
            "R1", "reset state", {bridge_rst_n, busy, done, err, acc_req}, 0);

        // A: readback, 24 bpp, 4 lanes, own reference clock
        run_seq(0, 0, "R9");

        // B: no readback, 18 loose, 2 lanes, pixel reference, zero on-delay,
        // restart from done, stray start while busy
        vback = 8'd250; hback = 8'd250;   // sums wrap modulo 256 (R3)
        set_cfg(0, 5'd18, 1, 3'd2, 1, 16'h1234, 16'h0007, 8'd1, 8'd0);
        run_seq(0, 1, "R12");

        // C: 16 bpp, 1 lane
        vback = 8'd2; hback = 8'd3; hactive = 16'd320; vactive = 16'd240;
        set_cfg(1, 5'd16, 0, 3'd1, 0, 16'hC0DE, 16'h0001, 8'd2, 8'd1);
        run_seq(0, 0, "R4");

        // D: identity mismatch
        id_val = 16'h2827;
        set_cfg(1, 5'd18, 0, 3'd3, 0, 16'h0101, 16'h0002, 8'd1, 8'd1);
        run_seq(1, 0, "R2");
        id_val = 16'h2828;

        // E: control word mismatch
        ctl_val = 16'h0300;
        run_seq(1, 0, "R2");
        ctl_val = 16'h0301;

        // F: unsupported colour depth
        set_cfg(0, 5'd20, 0, 3'd2, 0, 16'h0101, 16'h0002, 8'd1, 8'd1);
        run_seq(1, 0, "R5");

        // G: restart after error, 18 packed
        set_cfg(1, 5'd18, 0, 3'd3, 1, 16'h5A5A, 16'h0004, 8'd2, 8'd2);
        run_seq(0, 0, "R12");

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule